// File: doc/BRIEF.md
# Shared-Bus Glue and Address Decoder

This block is the glue between an 8-bit processor with a multiplexed low-address/data bus, a helper microcontroller that can take over that same bus, one static RAM and one serial UART. Either master drives the bus: when the takeover request (`hold`) is high, the processor's address, read, write and memory/IO lines count as floating and the microcontroller's versions are used instead; when it is low, the processor's lines are used.

The low address byte is captured from the shared data bus by a latch that is open while either master's address strobe is high and keeps its last value once both strobes are low. From the selected master's lines and the latched byte, the block makes the RAM chip enable (active low, lower half of the address space, memory cycles only), and the UART chip select, register select, bus enable strobe and read/write direction. The UART decode looks at only three address bits, so the UART appears at every I/O address whose bit 7 is 0 and bit 4 is 1. Its two registers therefore appear at octal 020 and 021, along with many aliases.

Top module: `bus_glue_top`

## Requirements
- R1: After reset, with both address strobes low, `addr_lo` reads 0. While either strobe is high, `addr_lo` equals `dbus` in the same cycle. Once both strobes are low, `addr_lo` keeps the value `dbus` had at the last clock edge on which a strobe was high.
- R2: `cpu_ale` and `mcu_ale` each open the latch, whatever the level of `hold`.
- R3: `ram_ce_n` is 0 exactly when the selected address top bit is 0, the selected memory/IO line is 0 (a memory cycle), and the selected read or write strobe is 0.
- R4: `uart_cs` is 1 exactly when the selected memory/IO line is 1 (an I/O cycle), `addr_lo[7]` is 0, `addr_lo[4]` is 1 and a selected strobe is 0. No other address bits matter.
- R5: `uart_rs` equals `addr_lo[0]`.
- R6: `uart_e` is 1 exactly when the selected read strobe or the selected write strobe is 0.
- R7: `uart_rw` equals `cpu_s1` while `hold` is 0, and equals `mcu_s1` while `hold` is 1.
- R8: While `hold` is 1, the processor's address top bit, strobes and memory/IO line have no effect on the outputs. While `hold` is 0, the microcontroller's have none.
- R9: While both selected strobes are 1, `ram_ce_n` is 1, `uart_cs` is 0 and `uart_e` is 0.
- R10: `ram_ce_n` = 0 and `uart_cs` = 1 never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to hold the latched address byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbus | input | 8 | Shared multiplexed low-address/data bus |
| hold | input | 1 | 1 = microcontroller owns the bus |
| cpu_a_top | input | 1 | Processor address bit 15 |
| cpu_ale | input | 1 | Processor address strobe |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_io_m | input | 1 | Processor cycle type, 1 = I/O, 0 = memory |
| cpu_s1 | input | 1 | Processor early read/write status |
| mcu_a_top | input | 1 | Microcontroller address bit 15 |
| mcu_ale | input | 1 | Microcontroller address strobe |
| mcu_rd_n | input | 1 | Microcontroller read strobe, active low |
| mcu_wr_n | input | 1 | Microcontroller write strobe, active low |
| mcu_io_m | input | 1 | Microcontroller cycle type, 1 = I/O |
| mcu_s1 | input | 1 | Microcontroller read/write status |
| addr_lo | output | 8 | Latched low address byte |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| uart_cs | output | 1 | UART chip select, active high |
| uart_rs | output | 1 | UART register select |
| uart_e | output | 1 | UART bus enable strobe |
| uart_rw | output | 1 | UART read/write direction |

## Verification
The only stored state is the held address byte. If it is wrong, the fault shows on `addr_lo` in the first cycle after both strobes fall. It then spreads at once to `uart_rs`, and to `uart_cs` on the next I/O strobe. Everything else is combinational from the selected master. A wrong ownership choice shows in the same cycle, because a strobe on the idle master moves `ram_ce_n` or `uart_e`. A decode fault shows as an enable on an address or cycle type outside its region, or as `ram_ce_n` and `uart_cs` active together. A full sweep of address, cycle type and strobe combinations catches such a fault in the cycle it occurs.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

  typedef struct packed {
    logic a_top;
    logic rd_n;
    logic wr_n;
    logic io_m;
    logic s1;
  } bus_ctl_t;

  function automatic logic strobe_on(input logic rd_n, input logic wr_n);
    return (~rd_n) | (~wr_n);
  endfunction

  function automatic logic ram_region(input logic a_top, input logic io_m);
    return (~a_top) & (~io_m);
  endfunction

  function automatic logic io_match(input logic [7:0] a, input logic [7:0] mask,
                                    input logic [7:0] match);
    return (a & mask) == match;
  endfunction

endpackage

// File: rtl/bus_owner_mux.sv
module bus_owner_mux
  import bus_glue_pkg::*;
(
  input  logic     hold,
  input  bus_ctl_t cpu_ctl,
  input  bus_ctl_t mcu_ctl,
  output bus_ctl_t sel_ctl
);
  always_comb begin
    if (hold) sel_ctl = mcu_ctl;
    else      sel_ctl = cpu_ctl;
  end
endmodule

// File: rtl/low_addr_latch.sv
module low_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_a,
  input  logic         le_b,
  input  logic [W-1:0] d,
  output logic         le_any,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q;

  assign le_any = le_a | le_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (le_any) held_q <= d;
  end

  assign q = le_any ? d : held_q;
endmodule

// File: rtl/select_decode.sv
module select_decode
  import bus_glue_pkg::*;
#(
  parameter int         W          = 8,
  parameter logic [7:0] UART_MASK  = 8'h90,
  parameter logic [7:0] UART_MATCH = 8'h10,
  parameter int         RS_BIT     = 0
) (
  input  bus_ctl_t     ctl,
  input  logic [W-1:0] a_lo,
  output logic         ram_ce_n,
  output logic         uart_cs,
  output logic         uart_rs,
  output logic         uart_e,
  output logic         uart_rw
);
  logic active;
  assign active = strobe_on(ctl.rd_n, ctl.wr_n);

  always_comb begin
    ram_ce_n = ~(active & ram_region(ctl.a_top, ctl.io_m));
    uart_cs  = active & ctl.io_m & io_match(a_lo, UART_MASK, UART_MATCH);
    uart_e   = active;
    uart_rw  = ctl.s1;
    uart_rs  = a_lo[RS_BIT];
  end
endmodule

// File: rtl/bus_glue_top.sv
module bus_glue_top
  import bus_glue_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [7:0] UART_MASK  = 8'h90,
  parameter logic [7:0] UART_MATCH = 8'h10,
  parameter int         RS_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dbus,
  input  logic              hold,
  input  logic              cpu_a_top,
  input  logic              cpu_ale,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic              cpu_io_m,
  input  logic              cpu_s1,
  input  logic              mcu_a_top,
  input  logic              mcu_ale,
  input  logic              mcu_rd_n,
  input  logic              mcu_wr_n,
  input  logic              mcu_io_m,
  input  logic              mcu_s1,
  output logic [DATA_W-1:0] addr_lo,
  output logic              ram_ce_n,
  output logic              uart_cs,
  output logic              uart_rs,
  output logic              uart_e,
  output logic              uart_rw
);
  bus_ctl_t cpu_ctl, mcu_ctl, sel_ctl;
  logic     le_any;

  assign cpu_ctl = '{a_top: cpu_a_top, rd_n: cpu_rd_n, wr_n: cpu_wr_n,
                     io_m: cpu_io_m, s1: cpu_s1};
  assign mcu_ctl = '{a_top: mcu_a_top, rd_n: mcu_rd_n, wr_n: mcu_wr_n,
                     io_m: mcu_io_m, s1: mcu_s1};

  bus_owner_mux u_mux (
    .hold    (hold),
    .cpu_ctl (cpu_ctl),
    .mcu_ctl (mcu_ctl),
    .sel_ctl (sel_ctl)
  );

  low_addr_latch #(.W(DATA_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_a   (cpu_ale),
    .le_b   (mcu_ale),
    .d      (dbus),
    .le_any (le_any),
    .q      (addr_lo)
  );

  select_decode #(
    .W          (DATA_W),
    .UART_MASK  (UART_MASK),
    .UART_MATCH (UART_MATCH),
    .RS_BIT     (RS_BIT)
  ) u_dec (
    .ctl      (sel_ctl),
    .a_lo     (addr_lo),
    .ram_ce_n (ram_ce_n),
    .uart_cs  (uart_cs),
    .uart_rs  (uart_rs),
    .uart_e   (uart_e),
    .uart_rw  (uart_rw)
  );
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk #(
  parameter logic [7:0] UART_MASK  = 8'h90,
  parameter logic [7:0] UART_MATCH = 8'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] dbus,
  input logic       hold,
  input logic       le_any,
  input logic       sel_a_top,
  input logic       sel_rd_n,
  input logic       sel_wr_n,
  input logic       sel_io_m,
  input logic       cpu_s1,
  input logic       mcu_s1,
  input logic [7:0] addr_lo,
  input logic       ram_ce_n,
  input logic       uart_cs,
  input logic       uart_rs,
  input logic       uart_e,
  input logic       uart_rw
);
  // R1: a closed latch shows the byte captured on the last open edge
  p_latch_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_any && $past(le_any && rst_n)) |-> addr_lo == $past(dbus));

  // R1: a closed latch stays put
  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_any && !$past(le_any)) |-> $stable(addr_lo));

  // R3
  p_ram_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> (!sel_a_top && !sel_io_m && (!sel_rd_n || !sel_wr_n)));

  // R4
  p_uart_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uart_cs |-> (sel_io_m && ((addr_lo & UART_MASK) == UART_MATCH)));

  // R5
  p_rs_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uart_rs == addr_lo[0]);

  // R7
  p_rw_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uart_rw == (hold ? mcu_s1 : cpu_s1));

  // R9
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd_n && sel_wr_n) |-> (ram_ce_n && !uart_cs && !uart_e));

  // R10
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(uart_cs && !ram_ce_n));
endmodule

bind bus_glue_top bus_glue_chk #(.UART_MASK(UART_MASK), .UART_MATCH(UART_MATCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbus      (dbus),
  .hold      (hold),
  .le_any    (le_any),
  .sel_a_top (sel_ctl.a_top),
  .sel_rd_n  (sel_ctl.rd_n),
  .sel_wr_n  (sel_ctl.wr_n),
  .sel_io_m  (sel_ctl.io_m),
  .cpu_s1    (cpu_s1),
  .mcu_s1    (mcu_s1),
  .addr_lo   (addr_lo),
  .ram_ce_n  (ram_ce_n),
  .uart_cs   (uart_cs),
  .uart_rs   (uart_rs),
  .uart_e    (uart_e),
  .uart_rw   (uart_rw)
);

// File: tb/bus_glue_top_tb.sv
module bus_glue_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] dbus = 8'h00;
  logic hold = 1'b0;
  logic cpu_a_top = 1'b0, cpu_ale = 1'b0, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic cpu_io_m = 1'b0, cpu_s1 = 1'b0;
  logic mcu_a_top = 1'b0, mcu_ale = 1'b0, mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
  logic mcu_io_m = 1'b0, mcu_s1 = 1'b0;
  logic [7:0] addr_lo;
  logic ram_ce_n, uart_cs, uart_rs, uart_e, uart_rw;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_glue_top u_dut (
    .clk(clk), .rst_n(rst_n), .dbus(dbus), .hold(hold),
    .cpu_a_top(cpu_a_top), .cpu_ale(cpu_ale), .cpu_rd_n(cpu_rd_n),
    .cpu_wr_n(cpu_wr_n), .cpu_io_m(cpu_io_m), .cpu_s1(cpu_s1),
    .mcu_a_top(mcu_a_top), .mcu_ale(mcu_ale), .mcu_rd_n(mcu_rd_n),
    .mcu_wr_n(mcu_wr_n), .mcu_io_m(mcu_io_m), .mcu_s1(mcu_s1),
    .addr_lo(addr_lo), .ram_ce_n(ram_ce_n), .uart_cs(uart_cs),
    .uart_rs(uart_rs), .uart_e(uart_e), .uart_rw(uart_rw)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // move to the falling edge, then let combinational outputs settle
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_all();
    cpu_ale = 0; mcu_ale = 0;
    cpu_rd_n = 1; cpu_wr_n = 1; mcu_rd_n = 1; mcu_wr_n = 1;
    cpu_io_m = 0; mcu_io_m = 0; cpu_a_top = 0; mcu_a_top = 0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 reset addr", addr_lo, 8'h00);
    chk("R9 reset ce", {7'b0, ram_ce_n}, 8'h01);
    chk("R9 reset cs", {7'b0, uart_cs}, 8'h00);
    chk("R9 reset e", {7'b0, uart_e}, 8'h00);
  endtask

  task automatic t_latch();
    step(); dbus = 8'h5a; cpu_ale = 1; settle();
    chk("R1 transparent", addr_lo, 8'h5a);
    step(); cpu_ale = 0; dbus = 8'hc3; settle();
    chk("R1 hold after cpu strobe", addr_lo, 8'h5a);
    step(); settle();
    chk("R1 still held", addr_lo, 8'h5a);
    step(); hold = 1; mcu_ale = 1; dbus = 8'h21; settle();
    chk("R2 mcu strobe opens", addr_lo, 8'h21);
    step(); mcu_ale = 0; dbus = 8'hff; settle();
    chk("R2 hold after mcu strobe", addr_lo, 8'h21);
    step(); hold = 0; mcu_ale = 1; dbus = 8'h77; settle();
    chk("R2 mcu strobe with hold low", addr_lo, 8'h77);
    step(); mcu_ale = 0; hold = 1; cpu_ale = 1; dbus = 8'h3c; settle();
    chk("R2 cpu strobe with hold high", addr_lo, 8'h3c);
    step(); cpu_ale = 0; hold = 0; dbus = 8'h00; settle();
    chk("R2 held", addr_lo, 8'h3c);
  endtask

  task automatic t_uart();
    step(); dbus = 8'o020; cpu_ale = 1; step(); cpu_ale = 0; dbus = 8'h00;
    cpu_io_m = 1; cpu_rd_n = 0; cpu_s1 = 1; settle();
    chk("R4 octal 020 select", {7'b0, uart_cs}, 8'h01);
    chk("R5 rs at 020", {7'b0, uart_rs}, 8'h00);
    chk("R6 e on read", {7'b0, uart_e}, 8'h01);
    chk("R7 rw from cpu", {7'b0, uart_rw}, 8'h01);
    chk("R3 no ram on io", {7'b0, ram_ce_n}, 8'h01);
    step(); cpu_rd_n = 1; cpu_ale = 1; dbus = 8'o021; step(); cpu_ale = 0;
    cpu_wr_n = 0; cpu_s1 = 0; settle();
    chk("R5 rs at 021", {7'b0, uart_rs}, 8'h01);
    chk("R4 021 select", {7'b0, uart_cs}, 8'h01);
    chk("R6 e on write", {7'b0, uart_e}, 8'h01);
    chk("R7 rw low", {7'b0, uart_rw}, 8'h00);
    step(); cpu_wr_n = 1; cpu_ale = 1; dbus = 8'h7e; step(); cpu_ale = 0;
    cpu_rd_n = 0; settle();
    chk("R4 alias 0x7e", {7'b0, uart_cs}, 8'h01);
    step(); cpu_rd_n = 1; cpu_ale = 1; dbus = 8'h90; step(); cpu_ale = 0;
    cpu_rd_n = 0; settle();
    chk("R4 bit7 set rejects", {7'b0, uart_cs}, 8'h00);
    step(); idle_all(); settle();
  endtask

  task automatic t_ram();
    step(); cpu_a_top = 0; cpu_io_m = 0; cpu_rd_n = 0; settle();
    chk("R3 low half read", {7'b0, ram_ce_n}, 8'h00);
    step(); cpu_a_top = 1; settle();
    chk("R3 upper half off", {7'b0, ram_ce_n}, 8'h01);
    step(); cpu_a_top = 0; cpu_rd_n = 1; cpu_wr_n = 0; settle();
    chk("R3 low half write", {7'b0, ram_ce_n}, 8'h00);
    step(); cpu_io_m = 1; settle();
    chk("R3 io cycle off", {7'b0, ram_ce_n}, 8'h01);
    step(); idle_all(); settle();
  endtask

  task automatic t_owner();
    step(); hold = 1; cpu_rd_n = 0; cpu_io_m = 0; cpu_a_top = 0;
    cpu_s1 = 0; mcu_s1 = 1; settle();
    chk("R8 cpu ignored under hold ce", {7'b0, ram_ce_n}, 8'h01);
    chk("R8 cpu ignored under hold e", {7'b0, uart_e}, 8'h00);
    chk("R7 rw from mcu", {7'b0, uart_rw}, 8'h01);
    step(); mcu_wr_n = 0; settle();
    chk("R8 mcu write reaches ram", {7'b0, ram_ce_n}, 8'h00);
    step(); mcu_a_top = 1; cpu_a_top = 0; settle();
    chk("R8 mcu address top used", {7'b0, ram_ce_n}, 8'h01);
    step(); hold = 0; cpu_rd_n = 1; mcu_a_top = 0; settle();
    chk("R8 mcu ignored without hold", {7'b0, uart_e}, 8'h00);
    chk("R7 rw back to cpu", {7'b0, uart_rw}, 8'h00);
    step(); idle_all(); settle();
    chk("R9 idle after", {7'b0, uart_e}, 8'h00);
  endtask

  task automatic t_sweep();
    for (int own = 0; own < 2; own++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 16; c++) begin
          logic top, io, rdn, wrn, act, exp_ce_n, exp_cs;
          step();
          top = c[0]; io = c[1]; rdn = c[2]; wrn = c[3];
          idle_all();
          hold = own[0];
          dbus = a[7:0];
          if (own == 0) begin
            cpu_ale = 1; cpu_a_top = top; cpu_io_m = io; cpu_rd_n = rdn; cpu_wr_n = wrn;
          end else begin
            mcu_ale = 1; mcu_a_top = top; mcu_io_m = io; mcu_rd_n = rdn; mcu_wr_n = wrn;
          end
          settle();
          act = !rdn || !wrn;
          exp_ce_n = !(act && !top && !io);
          exp_cs = act && io && !dbus[7] && dbus[4];
          if (ram_ce_n !== exp_ce_n) chk("R3 sweep", {7'b0, ram_ce_n}, {7'b0, exp_ce_n});
          if (uart_cs !== exp_cs) chk("R4 sweep", {7'b0, uart_cs}, {7'b0, exp_cs});
          if (uart_e !== act) chk("R6 sweep", {7'b0, uart_e}, {7'b0, act});
          chk("R10 exclusive", {7'b0, uart_cs && !ram_ce_n}, 8'h00);
        end
    step(); idle_all(); hold = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset();
    t_latch();
    t_uart();
    t_ram();
    t_owner();
    t_sweep();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule